// File: doc/BRIEF.md
# Chained Buffer Descriptor Walker

This block is the front end of a storage controller's internal DMA that decides which memory buffers the data mover should visit. Software loads four configuration registers: the address where a descriptor chain lives, and the link word, buffer address and buffer size of the first buffer. Then it writes the control register to start the walk, either for one buffer alone or for a chain of buffers.

For each buffer the walker presents one command (address, byte count, acknowledge flag) to the data mover and waits for the mover's completion pulse. In chain mode it then reads the next descriptor over a word-wide read port. A descriptor is three words: link word, buffer address, buffer size. It repeats this until it has served a buffer whose link word does not request another link. Misaligned buffers end the walk with an error flag, and writing zero to the control register aborts the walk at any point.

Top module: `dma_chain_walker`

## Requirements
- R1: After synchronous reset, `busy`, `mv_valid`, `rd_valid`, `list_done` and `err` are all low.
- R2: Configuration writes use `cfg_addr` 0 = control, 1 = chain address, 2 = first link word, 3 = first buffer address, 4 = first buffer size. A control write with bit 0 set and bit 1 clear, made while idle, starts single-buffer mode. In that mode exactly one command is issued, using registers 3 and 4. No descriptor read is made. `list_done` pulses after the mover's `mv_done`.
- R3: A control write with bits 0 and 1 set starts chain mode. The first command uses registers 2 to 4. The next descriptor lives at the chain address plus the link word's bits 15:2 times 4. It is read as three single-word requests at +0, +4 and +8, giving link, address and size.
- R4: No descriptor read for the next buffer starts before `mv_done` has been seen for the current buffer.
- R5: A buffer whose link word has bit 31 (continue) clear is the last one. After its `mv_done`, `list_done` is high for exactly one cycle and `busy` falls.
- R6: When a fetched link word has bit 30 (new size) clear, the previous buffer size is reused and the fetched size word is ignored.
- R7: A buffer address that is not a multiple of 4 sets `err`, issues no command for that buffer and ends the walk without `list_done`.
- R8: The size of a buffer that is not the last must be a multiple of 2**SIZE_ALIGN_LOG2 (8 by default), else `err` as in R7. The size of the last buffer is unconstrained.
- R9: A control write of zero stops the walker. On the next cycle `busy`, `mv_valid` and `rd_valid` are low, and no further command or read follows.
- R10: Bit 29 of the buffer's link word is presented on `mv_ack` with its command in chain mode. It is 0 in single-buffer mode.
- R11: While `mv_valid` is high and `mv_ready` low, the command and its fields hold steady.
- R12: Starting a new walk clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| mv_valid | output | 1 | Transfer command valid |
| mv_ready | input | 1 | Mover accepts command |
| mv_addr | output | 32 | Buffer address of command |
| mv_bytes | output | BYTES_W | Byte count of command |
| mv_ack | output | 1 | Buffer acknowledge flag of command |
| mv_done | input | 1 | Mover finished the current buffer |
| rd_valid | output | 1 | Descriptor word read request |
| rd_ready | input | 1 | Memory accepts read request |
| rd_addr | output | 32 | Descriptor word address |
| rd_rvalid | input | 1 | Read data valid, fixed latency after accept |
| rd_rdata | input | 32 | Read data word |
| busy | output | 1 | Walk in progress |
| list_done | output | 1 | One-cycle pulse when the last buffer completes |
| err | output | 1 | Alignment fault stopped the walk |

## Verification
A corrupted chain pointer or word index shows up at the read port, two cycles after the previous buffer's completion. There the request address departs from chain address plus link offset. A size register that is not kept for a no-new-size descriptor surfaces in the byte count of the very next command. The scoreboard compares every command and every read address in order. So a skipped, repeated or reordered buffer is reported at the first handshake it disturbs. A missing error or a lost stop shows as an unexpected command with an empty queue, or as a wrong `err`, `busy` or completion count when the walk settles.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ISSUE,
    ST_WAIT,
    ST_FETCH
  } walk_st_e;

  // link word fields
  localparam int LNK_CONT = 31;
  localparam int LNK_NEWSZ = 30;
  localparam int LNK_ACK = 29;
  localparam int LNK_OFF_HI = 15;
  localparam int LNK_OFF_LO = 2;

  // configuration register select codes
  localparam logic [2:0] CFG_CTRL = 3'd0;
  localparam logic [2:0] CFG_CHAIN = 3'd1;
  localparam logic [2:0] CFG_LINK = 3'd2;
  localparam logic [2:0] CFG_BASE = 3'd3;
  localparam logic [2:0] CFG_SIZE = 3'd4;

endpackage

// File: rtl/dcw_align_chk.sv
module dcw_align_chk #(
  parameter int SIZE_ALIGN_LOG2 = 3
) (
  input  logic [31:0] buf_base,
  input  logic [31:0] buf_size,
  input  logic        is_last,
  output logic        fault
);
  logic size_bad;

  generate
    if (SIZE_ALIGN_LOG2 == 0) begin : g_no_size_rule
      assign size_bad = 1'b0;
    end else begin : g_size_rule
      assign size_bad = !is_last && (buf_size[SIZE_ALIGN_LOG2-1:0] != '0);
    end
  endgenerate

  assign fault = (buf_base[1:0] != 2'b00) || size_bad;
endmodule

// File: rtl/dcw_desc_fetch.sv
module dcw_desc_fetch (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        abort,
  input  logic [31:0] desc_addr,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [31:0] rd_addr,
  input  logic        rd_rvalid,
  input  logic [31:0] rd_rdata,
  output logic        desc_valid,
  output logic [31:0] desc_link,
  output logic [31:0] desc_base,
  output logic [31:0] desc_size
);
  localparam int WORDS = 3;

  logic [1:0] idx;
  logic       waiting;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      rd_valid   <= 1'b0;
      rd_addr    <= '0;
      waiting    <= 1'b0;
      idx        <= '0;
      desc_valid <= 1'b0;
    end else begin
      desc_valid <= 1'b0;
      if (start) begin
        rd_valid <= 1'b1;
        rd_addr  <= desc_addr;
        idx      <= '0;
        waiting  <= 1'b0;
      end else begin
        if (rd_valid && rd_ready) begin
          rd_valid <= 1'b0;
          waiting  <= 1'b1;
        end
        if (waiting && rd_rvalid) begin
          waiting <= 1'b0;
          case (idx)
            2'd0:    desc_link <= rd_rdata;
            2'd1:    desc_base <= rd_rdata;
            default: desc_size <= rd_rdata;
          endcase
          if (idx == 2'(WORDS - 1)) begin
            desc_valid <= 1'b1;
          end else begin
            idx      <= idx + 2'd1;
            rd_valid <= 1'b1;
            rd_addr  <= rd_addr + 32'd4;
          end
        end
      end
    end
  end

  p_rd_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready && !abort && !start) |=> (rd_valid && $stable(rd_addr)));

  p_one_outstanding_r3: assert property (@(posedge clk) disable iff (rst)
    waiting |-> !rd_valid);
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
  import dcw_pkg::*;
#(
  parameter int BYTES_W = 20,
  parameter int SIZE_ALIGN_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic               mv_valid,
  input  logic               mv_ready,
  output logic [31:0]        mv_addr,
  output logic [BYTES_W-1:0] mv_bytes,
  output logic               mv_ack,
  input  logic               mv_done,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [31:0]        rd_addr,
  input  logic               rd_rvalid,
  input  logic [31:0]        rd_rdata,
  output logic               busy,
  output logic               list_done,
  output logic               err
);
  localparam int PAD_W = 32 - (LNK_OFF_HI + 1);

  walk_st_e    state;
  logic [31:0] r_chain, r_link, r_base, r_size;
  logic [31:0] cur_link, cur_base, cur_size;
  logic        chain_mode;
  logic        fetch_start;
  logic [31:0] fetch_addr;
  logic        desc_valid;
  logic [31:0] desc_link, desc_base, desc_size;
  logic        is_last, fault;
  logic        ctrl_wr, stop_req, start_req;

  assign ctrl_wr   = cfg_we && (cfg_addr == CFG_CTRL);
  assign stop_req  = ctrl_wr && (cfg_wdata == 32'd0);
  assign start_req = ctrl_wr && cfg_wdata[0] && (state == ST_IDLE);
  assign is_last   = !chain_mode || !cur_link[LNK_CONT];
  assign busy      = (state != ST_IDLE);

  dcw_align_chk #(.SIZE_ALIGN_LOG2(SIZE_ALIGN_LOG2)) u_align (
    .buf_base(cur_base),
    .buf_size(cur_size),
    .is_last (is_last),
    .fault   (fault)
  );

  dcw_desc_fetch u_fetch (
    .clk       (clk),
    .rst       (rst),
    .start     (fetch_start),
    .abort     (stop_req),
    .desc_addr (fetch_addr),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .rd_rvalid (rd_rvalid),
    .rd_rdata  (rd_rdata),
    .desc_valid(desc_valid),
    .desc_link (desc_link),
    .desc_base (desc_base),
    .desc_size (desc_size)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      r_chain     <= '0;
      r_link      <= '0;
      r_base      <= '0;
      r_size      <= '0;
      cur_link    <= '0;
      cur_base    <= '0;
      cur_size    <= '0;
      chain_mode  <= 1'b0;
      fetch_start <= 1'b0;
      fetch_addr  <= '0;
      mv_valid    <= 1'b0;
      mv_addr     <= '0;
      mv_bytes    <= '0;
      mv_ack      <= 1'b0;
      list_done   <= 1'b0;
      err         <= 1'b0;
    end else begin
      list_done   <= 1'b0;
      fetch_start <= 1'b0;
      if (cfg_we) begin
        case (cfg_addr)
          CFG_CHAIN: r_chain <= cfg_wdata;
          CFG_LINK:  r_link  <= cfg_wdata;
          CFG_BASE:  r_base  <= cfg_wdata;
          CFG_SIZE:  r_size  <= cfg_wdata;
          default:   ;
        endcase
      end
      if (stop_req) begin
        state    <= ST_IDLE;
        mv_valid <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: if (start_req) begin
            chain_mode <= cfg_wdata[1];
            cur_link   <= cfg_wdata[1] ? r_link : 32'd0;
            cur_base   <= r_base;
            cur_size   <= r_size;
            err        <= 1'b0;
            state      <= ST_CHECK;
          end
          ST_CHECK: if (fault) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end else begin
            mv_valid <= 1'b1;
            mv_addr  <= cur_base;
            mv_bytes <= cur_size[BYTES_W-1:0];
            mv_ack   <= chain_mode && cur_link[LNK_ACK];
            state    <= ST_ISSUE;
          end
          ST_ISSUE: if (mv_ready) begin
            mv_valid <= 1'b0;
            state    <= ST_WAIT;
          end
          ST_WAIT: if (mv_done) begin
            if (is_last) begin
              list_done <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              fetch_start <= 1'b1;
              fetch_addr  <= r_chain +
                {{PAD_W{1'b0}}, cur_link[LNK_OFF_HI:LNK_OFF_LO], 2'b00};
              state       <= ST_FETCH;
            end
          end
          ST_FETCH: if (desc_valid) begin
            cur_link <= desc_link;
            cur_base <= desc_base;
            if (desc_link[LNK_NEWSZ]) cur_size <= desc_size;
            state    <= ST_CHECK;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mv_valid && !mv_ready && !stop_req) |=>
      (mv_valid && $stable(mv_addr) && $stable(mv_bytes) && $stable(mv_ack)));

  p_stop_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> (!mv_valid && !rd_valid && !busy));

  p_cmd_aligned_r7: assert property (@(posedge clk) disable iff (rst)
    mv_valid |-> (mv_addr[1:0] == 2'b00));

  p_single_nofetch_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && !chain_mode) |-> !rd_valid);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    list_done |=> !list_done);

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    err |-> !mv_valid);

  p_no_early_fetch_r4: assert property (@(posedge clk) disable iff (rst)
    mv_valid |-> !rd_valid);
endmodule

// File: tb/dma_chain_walker_bench.sv
`timescale 1ns/1ps
module dma_chain_walker_bench;
  localparam int BW = 20;

  typedef struct packed {
    logic [31:0] addr;
    logic [BW-1:0] bytes;
    logic ack;
  } cmd_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic mv_valid, mv_ack, rd_valid, busy, list_done, err;
  logic [31:0] mv_addr, rd_addr;
  logic [BW-1:0] mv_bytes;
  logic mv_ready, mv_done, rd_ready, rd_rvalid;
  logic [31:0] rd_rdata;

  logic [31:0] mem [0:255];
  cmd_t exp_cmd[$];
  logic [31:0] exp_rd[$];
  int n_chk = 0, n_fail = 0, done_seen = 0, rd_seen = 0;
  bit stall = 0, hold_done = 0;
  int done_cnt = 0, pend_cnt = 0;
  logic [7:0] pend_idx;

  always #10 clk = ~clk;

  dma_chain_walker #(.BYTES_W(BW), .SIZE_ALIGN_LOG2(3)) u_dma_chain_walker (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_addr(mv_addr), .mv_bytes(mv_bytes),
    .mv_ack(mv_ack), .mv_done(mv_done), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .busy(busy), .list_done(list_done), .err(err)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_link(bit cont, bit newsz, bit ack, int off);
    return {cont, newsz, ack, 13'b0, off[15:2], 2'b00};
  endfunction

  task automatic cfg(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push_cmd(logic [31:0] a, int b, bit k);
    cmd_t c;
    c.addr = a; c.bytes = BW'(b); c.ack = k;
    exp_cmd.push_back(c);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  // environment: mover, memory and monitors, all acting at the falling edge
  initial begin
    mv_ready = 1'b1; mv_done = 1'b0; rd_ready = 1'b1; rd_rvalid = 1'b0; rd_rdata = '0;
    forever begin
      @(negedge clk);
      mv_done = 1'b0;
      rd_rvalid = 1'b0;
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin rd_rvalid = 1'b1; rd_rdata = mem[pend_idx]; end
      end
      if (done_cnt > 0) begin
        done_cnt--;
        if (done_cnt == 0 && !hold_done) mv_done = 1'b1;
      end
      if (!rst) begin
        if (mv_valid && mv_ready) begin
          if (exp_cmd.size() == 0) begin
            chk("R7/R9", "unexpected command addr", mv_addr, 32'hFFFF_FFFF);
          end else begin
            cmd_t e;
            e = exp_cmd.pop_front();
            chk("R3/R11", "command address", mv_addr, e.addr);
            chk("R6/R8", "command bytes", 32'(mv_bytes), 32'(e.bytes));
            chk("R10", "command ack flag", 32'(mv_ack), 32'(e.ack));
          end
          done_cnt = 3;
        end
        if (rd_valid && rd_ready) begin
          rd_seen++;
          if (exp_rd.size() == 0) chk("R2/R4", "unexpected read addr", rd_addr, 32'hFFFF_FFFF);
          else chk("R3", "read address", rd_addr, exp_rd.pop_front());
          pend_cnt = 2;
          pend_idx = rd_addr[9:2];
        end
        if (list_done) done_seen++;
      end
      mv_ready = stall ? ~mv_ready : 1'b1;
    end
  end

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "mv_valid", 32'(mv_valid), 0);
    chk("R1", "rd_valid", 32'(rd_valid), 0);
    chk("R1", "err", 32'(err), 0);
    chk("R1", "list_done", 32'(list_done), 0);

    // R2 single-buffer: link register ignored, odd size allowed (R8 last)
    cfg(3'd1, 32'h100);
    cfg(3'd2, mk_link(1, 1, 1, 12));
    cfg(3'd3, 32'h2000);
    cfg(3'd4, 100);
    push_cmd(32'h2000, 100, 0);
    cfg(3'd0, 32'h1);
    wait_idle();
    chk("R2", "done count", done_seen, 1);
    chk("R2", "no reads", rd_seen, 0);
    chk("R2", "commands left", exp_cmd.size(), 0);

    // R3 R5 R6 R8 R10 R11: three-buffer chain with stalled mover
    mem[(32'h10C >> 2)]     = mk_link(1, 0, 1, 24);
    mem[(32'h10C >> 2) + 1] = 32'h1400;
    mem[(32'h10C >> 2) + 2] = 32'd999;
    mem[(32'h118 >> 2)]     = mk_link(0, 1, 0, 0);
    mem[(32'h118 >> 2) + 1] = 32'h1800;
    mem[(32'h118 >> 2) + 2] = 32'd30;
    cfg(3'd2, mk_link(1, 1, 0, 12));
    cfg(3'd3, 32'h1000);
    cfg(3'd4, 64);
    push_cmd(32'h1000, 64, 0);
    push_cmd(32'h1400, 64, 1);
    push_cmd(32'h1800, 30, 0);
    for (int a = 32'h10C; a < 32'h124; a += 4) exp_rd.push_back(32'(a));
    stall = 1;
    cfg(3'd0, 32'h3);
    wait_idle();
    stall = 0;
    chk("R5", "done count", done_seen, 2);
    chk("R3", "reads made", rd_seen, 6);
    chk("R3", "commands left", exp_cmd.size(), 0);
    chk("R5", "busy after last", 32'(busy), 0);

    // R7 misaligned fetched base
    mem[(32'h124 >> 2)]     = mk_link(0, 1, 0, 0);
    mem[(32'h124 >> 2) + 1] = 32'h2002;
    mem[(32'h124 >> 2) + 2] = 32'd16;
    cfg(3'd2, mk_link(1, 1, 0, 36));
    cfg(3'd4, 8);
    push_cmd(32'h1000, 8, 0);
    for (int a = 32'h124; a < 32'h130; a += 4) exp_rd.push_back(32'(a));
    cfg(3'd0, 32'h3);
    wait_idle();
    chk("R7", "err set", 32'(err), 1);
    chk("R7", "no done", done_seen, 2);
    chk("R7", "commands left", exp_cmd.size(), 0);

    // R12 new start clears err
    cfg(3'd3, 32'h3000);
    cfg(3'd4, 4);
    push_cmd(32'h3000, 4, 0);
    cfg(3'd0, 32'h1);
    chk("R12", "err cleared", 32'(err), 0);
    wait_idle();
    chk("R12", "done count", done_seen, 3);

    // R8 non-last size not multiple of 8
    cfg(3'd2, mk_link(1, 1, 0, 12));
    cfg(3'd3, 32'h1000);
    cfg(3'd4, 12);
    cfg(3'd0, 32'h3);
    wait_idle();
    chk("R8", "err set", 32'(err), 1);
    chk("R8", "no reads", rd_seen, 9);
    chk("R8", "no done", done_seen, 3);

    // R9 stop while waiting for the mover; R4 no fetch before done
    hold_done = 1;
    cfg(3'd4, 64);
    push_cmd(32'h1000, 64, 0);
    cfg(3'd0, 32'h3);
    for (int i = 0; i < 100 && exp_cmd.size() != 0; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R4", "no read before done", rd_seen, 9);
    cfg(3'd0, 32'h0);
    chk("R9", "busy after stop", 32'(busy), 0);
    chk("R9", "mv_valid after stop", 32'(mv_valid), 0);
    hold_done = 0;
    repeat (30) @(negedge clk);
    chk("R9", "no reads after stop", rd_seen, 9);
    chk("R9", "no done after stop", done_seen, 3);
    chk("R9", "rd_valid after stop", 32'(rd_valid), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule